// File: doc/BRIEF.md
# Vector-Prefix Register Number Extender

This block widens a short register field taken from an instruction into a 7-bit register number. It also marks the operand as scalar or vector. It is purely combinational and serves the operand decode of a vector-extension prefix.

A 9-bit extension field is shared by several operands. Each operand owns one slot of that field. A 2-bit type code says whether slots are two bits wide, three bits wide, or absent. A 3-bit index picks the slot that belongs to this operand. The slot's top bit is the vector flag, and the remaining two bits are placed next to the base number.

A build parameter picks the variant. The general-register variant takes a 5-bit base. The condition-field variant takes a 3-bit base. When the selected extension bits are all zero, the base number comes out unchanged and the operand is scalar.

Top module: `vrx_reg_extend`

## Requirements
- R1: With type code 0 (none), the number equals the zero-extended base and the vector flag is 0, whatever the extension field and index hold.
- R2: With type code 2 (3-bit slots), index 1, 2 and 3 select extension bits [2:0], [5:3] and [8:6] respectively.
- R3: With type code 1 (2-bit slots), index 1, 2, 3 and 4 select extension bits [1:0], [3:2], [5:4] and [7:6]. The selected pair forms the upper two bits of a 3-bit spec whose lowest bit is 0.
- R4: The vector flag equals bit 2 of the 3-bit spec, which is the top bit of the selected slot.
- R5: The following all act as an all-zero spec, so the base passes through as a scalar: index 0; index 4 with type code 2; indices 5, 6 and 7; and type code 3.
- R6: General variant, scalar: number = {spec[1:0], base[4:0]}.
- R7: General variant, vector: number = {base[4:0], spec[1:0]}.
- R8: Condition variant, scalar: number = {2'b00, spec[1:0], base[2:0]}.
- R9: Condition variant, vector: number = {base[2:0], spec[1:0], 2'b00}.
- R10: When the selected slot is all zero, the number equals the zero-extended base and the vector flag is 0, in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_num | input | BASE_W | Register field from the instruction (5 or 3 bits) |
| ext_field | input | EXT_W | Shared extension field (9 bits) |
| ext_type | input | 2 | 0 none, 1 two-bit slots, 2 three-bit slots, 3 reserved |
| slot_idx | input | 3 | Slot select: 1..4 name slots, 0 and 5..7 select nothing |
| reg_num | output | REG_W | Extended register number (7 bits) |
| is_vec | output | 1 | Operand is a vector |

## Verification
Both variants are driven with the same extension field, type code and index. This means a slot-selection fault and a bit-placement fault show up differently across the two outputs.

Directed patterns give each slot a distinct value, so any swap of slots or off-by-one in a slice gives a wrong number. Separate directed patterns set only the vector flag, or only the low spec bits, to separate the scalar and vector placements.

Reserved type and index codes, and zero slots next to non-zero neighbours, confirm pass-through. A long run of pseudo-random inputs is then compared against a behavioural model.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
   localparam int SPEC_W = 3;

   typedef enum logic [1:0] {
      ET_NONE = 2'd0,
      ET_TWO  = 2'd1,
      ET_THREE = 2'd2,
      ET_RSVD = 2'd3
   } ext_type_e;

   typedef struct packed {
      logic       vec;
      logic [1:0] bits;
   } spec_t;
endpackage

// File: rtl/vrx_slot_pick.sv
module vrx_slot_pick #(
   parameter int EXT_W = 9
) (
   input  logic [EXT_W-1:0] ext_field,
   input  logic [1:0]       ext_type,
   input  logic [2:0]       slot_idx,
   output vrx_pkg::spec_t   spec
);
   import vrx_pkg::*;

   localparam int N3 = EXT_W / 3;
   localparam int N2 = EXT_W / 2;

   if (N3 < 1 || N2 < 1 || N2 > 7)
      $error("vrx_slot_pick: EXT_W out of range");

   logic [2:0] f3 [N3];
   logic [1:0] f2 [N2];

   for (genvar k = 0; k < N3; k++) begin : g_three
      assign f3[k] = ext_field[3*k +: 3];
   end
   for (genvar k = 0; k < N2; k++) begin : g_two
      assign f2[k] = ext_field[2*k +: 2];
   end

   logic [2:0] slot;
   assign slot = slot_idx - 3'd1;

   always_comb begin
      spec = '0;
      if (slot_idx != 3'd0) begin
         unique case (ext_type_e'(ext_type))
            ET_THREE: begin
               for (int k = 0; k < N3; k++)
                  if (slot == 3'(k)) spec = f3[k];
            end
            ET_TWO: begin
               for (int k = 0; k < N2; k++)
                  if (slot == 3'(k)) spec = {f2[k], 1'b0};
            end
            default: spec = '0;
         endcase
      end
   end

   // R3: a two-bit slot never produces a set lowest spec bit
   always_comb begin
      if (ext_type == 2'd1)
         a_r3_two_low_zero: assert (spec.bits[0] == 1'b0);
   end
endmodule

// File: rtl/vrx_widen.sv
module vrx_widen #(
   parameter int BASE_W = 5,
   parameter int REG_W  = 7
) (
   input  logic [BASE_W-1:0] base_num,
   input  vrx_pkg::spec_t    spec,
   output logic [REG_W-1:0]  reg_num,
   output logic              is_vec
);
   localparam int PAD = REG_W - BASE_W;

   assign is_vec = spec.vec;

   if (BASE_W == 5) begin : g_gpr
      if (REG_W < BASE_W + 2) $error("vrx_widen: REG_W too small");
      always_comb begin
         if (spec.vec) reg_num = REG_W'({base_num, spec.bits});
         else          reg_num = REG_W'({spec.bits, base_num});
      end
      always_comb begin
         if (is_vec)
            a_r7_base_high: assert (reg_num[BASE_W+1:2] == base_num);
         else
            a_r6_base_low: assert (reg_num[BASE_W-1:0] == base_num);
      end
   end else if (BASE_W == 3) begin : g_cr
      if (REG_W < BASE_W + 4) $error("vrx_widen: REG_W too small");
      always_comb begin
         if (spec.vec) reg_num = REG_W'({base_num, spec.bits, 2'b00});
         else          reg_num = REG_W'({spec.bits, base_num});
      end
      always_comb begin
         if (is_vec)
            a_r9_low_fill: assert (reg_num[1:0] == 2'b00 && reg_num[BASE_W+3:4] == base_num);
         else
            a_r8_base_low: assert (reg_num[BASE_W-1:0] == base_num && reg_num[REG_W-1:BASE_W+2] == '0);
      end
   end else begin : g_bad
      $error("vrx_widen: BASE_W must be 5 or 3");
      assign reg_num = {{PAD{1'b0}}, base_num};
   end
endmodule

// File: rtl/vrx_reg_extend.sv
module vrx_reg_extend #(
   parameter int BASE_W = 5,
   parameter int EXT_W  = 9,
   parameter int REG_W  = 7
) (
   input  logic [BASE_W-1:0] base_num,
   input  logic [EXT_W-1:0]  ext_field,
   input  logic [1:0]        ext_type,
   input  logic [2:0]        slot_idx,
   output logic [REG_W-1:0]  reg_num,
   output logic              is_vec
);
   vrx_pkg::spec_t spec;

   vrx_slot_pick #(.EXT_W(EXT_W)) u_pick (
      .ext_field(ext_field),
      .ext_type (ext_type),
      .slot_idx (slot_idx),
      .spec     (spec)
   );

   vrx_widen #(.BASE_W(BASE_W), .REG_W(REG_W)) u_widen (
      .base_num(base_num),
      .spec    (spec),
      .reg_num (reg_num),
      .is_vec  (is_vec)
   );

   always_comb begin
      if (ext_type == 2'd0 || ext_type == 2'd3)
         a_r1_none_passthru: assert (reg_num == REG_W'(base_num) && !is_vec);
      if (slot_idx == 3'd0 || slot_idx > 3'd4 || (slot_idx == 3'd4 && ext_type == 2'd2))
         a_r5_unused_slot: assert (reg_num == REG_W'(base_num) && !is_vec);
   end
endmodule

// File: tb/vrx_reg_extend_bench.sv
module vrx_reg_extend_bench;
   logic clk = 1'b0;
   logic rst;
   always #2 clk = ~clk;

   logic [4:0] base_g;
   logic [2:0] base_c;
   logic [8:0] ext_field;
   logic [1:0] ext_type;
   logic [2:0] slot_idx;
   logic [6:0] num_g, num_c;
   logic       vec_g, vec_c;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   vrx_reg_extend u_vrx_reg_extend (
      .base_num(base_g), .ext_field(ext_field), .ext_type(ext_type),
      .slot_idx(slot_idx), .reg_num(num_g), .is_vec(vec_g));

   vrx_reg_extend #(.BASE_W(3)) u_vrx_reg_extend_cr (
      .base_num(base_c), .ext_field(ext_field), .ext_type(ext_type),
      .slot_idx(slot_idx), .reg_num(num_c), .is_vec(vec_c));

   function automatic int spec_of(int ext, int et, int ix);
      int s = 0;
      if (et == 2 && ix >= 1 && ix <= 3) s = (ext >> (3*(ix-1))) & 7;
      else if (et == 1 && ix >= 1 && ix <= 4) s = ((ext >> (2*(ix-1))) & 3) << 1;
      return s;
   endfunction

   function automatic int num_of(bit cr, int base, int s);
      int v = (s >> 2) & 1;
      int lo = s & 3;
      if (!cr) return v ? (base * 4 + lo) : (lo * 32 + base);
      return v ? (base * 16 + lo * 4) : (lo * 8 + base);
   endfunction

   task automatic check(string tag, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run_vec(string tag, int bg, int bc, int ext, int et, int ix);
      int s, ok_unused;
      string tg, tc;
      @(posedge clk); #1;
      base_g = 5'(bg); base_c = 3'(bc); ext_field = 9'(ext);
      ext_type = 2'(et); slot_idx = 3'(ix);
      @(negedge clk);
      s = spec_of(ext, et, ix);
      ok_unused = (ix == 0 || ix > 4 || et == 3 || (et == 2 && ix == 4));
      if (tag != "") begin tg = tag; tc = tag; end
      else if (et == 0) begin tg = "R1"; tc = "R1"; end
      else if (ok_unused) begin tg = "R5"; tc = "R5"; end
      else if (s == 0) begin tg = "R10"; tc = "R10"; end
      else begin
         tg = ((s >> 2) & 1) ? "R7" : "R6";
         tc = ((s >> 2) & 1) ? "R9" : "R8";
      end
      check(tg, int'(num_g), num_of(0, bg & 31, s));
      check(tc, int'(num_c), num_of(1, bc & 7, s));
      check("R4", int'(vec_g), (s >> 2) & 1);
      check("R4", int'(vec_c), (s >> 2) & 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      base_g = '0; base_c = '0; ext_field = '0; ext_type = '0; slot_idx = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset", int'(num_g), 0);
      check("R1 reset", int'(num_c), 0);
      check("R1 reset", int'(vec_g), 0);
      rst = 1'b0;
      // R1: type none ignores a full extension field
      run_vec("R1", 21, 5, 9'h1FF, 0, 1);
      run_vec("R1", 9, 2, 9'h1FF, 0, 3);
      // R2: distinct 3-bit slots 110, 011, 101 (bits [8:6],[5:3],[2:0])
      run_vec("R2", 19, 6, 9'b110_011_101, 2, 1);
      run_vec("R2", 19, 6, 9'b110_011_101, 2, 2);
      run_vec("R2", 19, 6, 9'b110_011_101, 2, 3);
      // R3: distinct 2-bit slots 01,10,11,10 from low to high
      run_vec("R3", 7, 3, 9'b0_10_11_10_01, 1, 1);
      run_vec("R3", 7, 3, 9'b0_10_11_10_01, 1, 2);
      run_vec("R3", 7, 3, 9'b0_10_11_10_01, 1, 3);
      run_vec("R3", 7, 3, 9'b0_10_11_10_01, 1, 4);
      // R5: unused codes
      run_vec("R5", 30, 7, 9'h1FF, 2, 4);
      run_vec("R5", 30, 7, 9'h1FF, 1, 5);
      run_vec("R5", 30, 7, 9'h1FF, 2, 7);
      run_vec("R5", 30, 7, 9'h1FF, 3, 2);
      run_vec("R5", 30, 7, 9'h1FF, 1, 0);
      // R6/R8 scalar with spec bits, R7/R9 vector with and without low bits
      run_vec("R6", 31, 7, 9'b000_000_011, 2, 1);
      run_vec("R8", 31, 7, 9'b000_000_011, 2, 1);
      run_vec("R7", 17, 5, 9'b000_100_000, 2, 2);
      run_vec("R9", 17, 5, 9'b000_111_000, 2, 2);
      // R10: zero slot beside non-zero neighbours
      run_vec("R10", 13, 4, 9'b111_000_111, 2, 2);
      run_vec("R10", 13, 4, 9'b1_11_00_11_11, 1, 3);
      for (int i = 0; i < 3000; i++)
         run_vec("", $urandom % 32, $urandom % 8, $urandom % 512,
                 $urandom % 4, $urandom % 8);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule